// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block is the timekeeping core of a real-time clock. It holds the running time and calendar as packed BCD: hundredths of a second, seconds, minutes, hours (24-hour form), day of week, day of month, month and a two-digit year. A century flag sits in the hours byte beside its own enable bit. When the year wraps from 99 to 00 the flag inverts, but only if the enable bit is set.

An external prescaler supplies a single-cycle 100 Hz enable, `tick`. Each tick advances the hundredths field. Carries then ripple up through the chain in the same cycle. Month lengths come from the month and the year, and February has 29 days in years divisible by four. The host loads fields through a byte-wide parallel port: an address selects the field and the data byte holds its new value. Any load restarts the sub-second count. A stop bit, kept in the seconds byte, freezes all counting until it is cleared.

The outputs show the internal values as register bytes. Bits that a field does not use read as zero.

Top module: `bcd_tod_chain`

## Requirements
- R1: Each `tick` while running and with no load in that cycle raises the hundredths field by one in BCD. The step from 99 goes to 00 and carries one into seconds.
- R2: A load to address 0 (hundredths) leaves the field at 00 whatever the data byte holds.
- R3: Seconds and minutes count 00 to 59 and carry on leaving 59. Hours count 00 to 23 and carry into the calendar on leaving 23.
- R4: In the hours byte, bit 7 is the century enable and bit 6 is the century flag; bits 5:0 hold the hours. The flag inverts at the year step 99 to 00 when the enable is 1, and it never changes by counting when the enable is 0.
- R5: The day of week occupies bits 2:0 of address 4. It counts 1 to 7 and then back to 1, and it advances together with the date on the hour carry.
- R6: The date steps past the last day of the month to 01 and advances the month. April, June, September and November have 30 days, and the other months except February have 31.
- R7: February has 29 days when the BCD year is divisible by four (00, 12, 24 and so on) and 28 days otherwise (10, 23 and so on).
- R8: The month counts 01 to 12 and carries into the year on leaving 12. The year counts 00 to 99 and wraps to 00.
- R9: Bit 7 of the seconds byte is the stop bit. While it is 1, ticks change no field. After a load clears it, counting resumes from hundredths 00, so seconds advance on the 100th tick.
- R10: Any load to any address clears the hundredths field to 00, which restarts the sub-second count.
- R11: When a load and a tick fall in the same cycle, the load is applied and that tick is dropped.
- R12: After reset the time reads 00:00:00.00, the day of week reads 1, the date reads 01, the month reads 01, the year reads 00, and the stop, century enable and century flag bits read 0.
- R13: The load address selects the field: 0 hundredths, 1 seconds and stop, 2 minutes, 3 hours with the century bits, 4 day of week, 5 date, 6 month, 7 year. Data bits outside a field are discarded and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | 100 Hz count enable, one cycle wide |
| ld_en | input | 1 | Load strobe |
| ld_addr | input | 3 | Field select for a load |
| ld_data | input | 8 | Value to load |
| hund_o | output | 8 | Hundredths, BCD |
| sec_o | output | 8 | Stop bit and seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Century enable, century flag, hours in BCD |
| wday_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
The hardest conditions to reach are the calendar edges: the end of a month, a February in a leap or a common year, and the year wrap with each setting of the century bits. Each of these needs hundredths at 99 with every lower field at its maximum. Hundredths cannot be loaded to anything but 00. So each scenario loads 23:59:59 and the chosen date, month, year and century bits, then issues exactly 100 ticks, and the final tick ripples one carry through the whole chain. Years such as 10 and 12 are chosen so that the BCD leap test differs from a test on the low bits of the raw byte.

// File: rtl/bcd_tod_chain.sv
module bcd_tod_chain (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ld_en,
  input  logic [2:0] ld_addr,
  input  logic [7:0] ld_data,
  output logic [7:0] hund_o,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);

  localparam logic [2:0] A_SEC  = 3'd1;
  localparam logic [2:0] A_MIN  = 3'd2;
  localparam logic [2:0] A_HOUR = 3'd3;
  localparam logic [2:0] A_WDAY = 3'd4;
  localparam logic [2:0] A_DATE = 3'd5;
  localparam logic [2:0] A_MON  = 3'd6;
  localparam logic [2:0] A_YEAR = 3'd7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] hund, yr;
  logic [6:0] sec, mins;
  logic [5:0] hr, date;
  logic [4:0] mon;
  logic [2:0] wday;
  logic       stop, ceb, cb;

  logic [7:0] hund_n, sec_n, min_n, hr_n, date_n, mon_n, yr_n;
  logic [1:0] ymod4;
  logic [5:0] mlen;
  logic       run, c_h, c_s, c_m, c_hr, c_d, c_mo, c_y;

  assign hund_n = bcd_inc(hund);
  assign sec_n  = bcd_inc({1'b0, sec});
  assign min_n  = bcd_inc({1'b0, mins});
  assign hr_n   = bcd_inc({2'b0, hr});
  assign date_n = bcd_inc({2'b0, date});
  assign mon_n  = bcd_inc({3'b0, mon});
  assign yr_n   = bcd_inc(yr);

  assign ymod4 = yr[1:0] + {yr[4], 1'b0};

  always_comb begin
    case (mon)
      5'h02:                      mlen = (ymod4 == 2'd0) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: mlen = 6'h30;
      default:                    mlen = 6'h31;
    endcase
  end

  assign run  = tick && !stop && !ld_en;
  assign c_h  = run  && (hund == 8'h99);
  assign c_s  = c_h  && (sec  == 7'h59);
  assign c_m  = c_s  && (mins == 7'h59);
  assign c_hr = c_m  && (hr   == 6'h23);
  assign c_d  = c_hr && (date >= mlen);
  assign c_mo = c_d  && (mon  == 5'h12);
  assign c_y  = c_mo && (yr   == 8'h99);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hund <= 8'h00;
      sec  <= 7'h00;
      mins <= 7'h00;
      hr   <= 6'h00;
      wday <= 3'd1;
      date <= 6'h01;
      mon  <= 5'h01;
      yr   <= 8'h00;
      stop <= 1'b0;
      ceb  <= 1'b0;
      cb   <= 1'b0;
    end else if (ld_en) begin
      hund <= 8'h00;
      case (ld_addr)
        A_SEC:  begin stop <= ld_data[7]; sec <= ld_data[6:0]; end
        A_MIN:  mins <= ld_data[6:0];
        A_HOUR: begin ceb <= ld_data[7]; cb <= ld_data[6]; hr <= ld_data[5:0]; end
        A_WDAY: wday <= ld_data[2:0];
        A_DATE: date <= ld_data[5:0];
        A_MON:  mon  <= ld_data[4:0];
        A_YEAR: yr   <= ld_data;
        default: ;
      endcase
    end else if (run) begin
      hund <= c_h ? 8'h00 : hund_n;
      if (c_h)  sec  <= c_s ? 7'h00 : sec_n[6:0];
      if (c_s)  mins <= c_m ? 7'h00 : min_n[6:0];
      if (c_m)  hr   <= c_hr ? 6'h00 : hr_n[5:0];
      if (c_hr) begin
        wday <= (wday >= 3'd7) ? 3'd1 : wday + 3'd1;
        date <= c_d ? 6'h01 : date_n[5:0];
      end
      if (c_d)  mon  <= c_mo ? 5'h01 : mon_n[4:0];
      if (c_mo) yr   <= c_y ? 8'h00 : yr_n;
      if (c_y && ceb) cb <= ~cb;
    end
  end

  assign hund_o  = hund;
  assign sec_o   = {stop, sec};
  assign min_o   = {1'b0, mins};
  assign hour_o  = {ceb, cb, hr};
  assign wday_o  = {5'b0, wday};
  assign date_o  = {2'b0, date};
  assign month_o = {3'b0, mon};
  assign year_o  = yr;

endmodule

// File: rtl/bcd_tod_chain_chk.sv
module bcd_tod_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       ld_en,
  input logic [2:0] ld_addr,
  input logic [7:0] ld_data,
  input logic [7:0] hund_o,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);

  logic day_edge;
  assign day_edge = tick && !sec_o[7] && !ld_en && hund_o == 8'h99 &&
                    sec_o[6:0] == 7'h59 && min_o == 8'h59 && hour_o[5:0] == 6'h23;

  AST_HUND_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sec_o[7] && !ld_en && hund_o != 8'h99) |=> hund_o != $past(hund_o)); // R1

  AST_LOAD_CLEARS_HUND: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> hund_o == 8'h00); // R10

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !ld_en) |=> ($stable(hund_o) && $stable(sec_o) && $stable(year_o))); // R9

  AST_CENTURY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hour_o[7] && !(ld_en && ld_addr == 3'd3)) |=> $stable(hour_o[6])); // R4

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    day_edge |=> (hour_o[5:0] == 6'h00 && min_o == 8'h00 && sec_o == 8'h00)); // R3

  AST_WDAY_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    day_edge |=> (wday_o != $past(wday_o) && wday_o != 8'h00)); // R5

endmodule

bind bcd_tod_chain bcd_tod_chain_chk u_chk (.*);

// File: tb/bcd_tod_chain_bench.sv
module bcd_tod_chain_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ld_en = 1'b0;
  logic [2:0] ld_addr = 3'd0;
  logic [7:0] ld_data = 8'h00;
  logic [7:0] hund_o, sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_tod_chain u_bcd_tod_chain (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .hund_o(hund_o), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .wday_o(wday_o), .date_o(date_o), .month_o(month_o),
    .year_o(year_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic load(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic roll_day(input logic [7:0] hb, input logic [7:0] wd, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr);
    load(3'd3, hb); load(3'd2, 8'h59); load(3'd1, 8'h59);
    load(3'd4, wd); load(3'd5, dt); load(3'd6, mo); load(3'd7, yr);
    ticks(100);
  endtask

  task automatic t_reset;
    chk("R12", "hund", hund_o, 8'h00);
    chk("R12", "sec", sec_o, 8'h00);
    chk("R12", "min", min_o, 8'h00);
    chk("R12", "hour", hour_o, 8'h00);
    chk("R12", "wday", wday_o, 8'h01);
    chk("R12", "date", date_o, 8'h01);
    chk("R12", "month", month_o, 8'h01);
    chk("R12", "year", year_o, 8'h00);
  endtask

  task automatic t_hund;
    load(3'd0, 8'h55);
    chk("R2", "hund after write 55", hund_o, 8'h00);
    ticks(9);
    chk("R1", "hund after 9 ticks", hund_o, 8'h09);
    ticks(1);
    chk("R1", "hund BCD step 09->10", hund_o, 8'h10);
    load(3'd0, 8'h37);
    chk("R2", "hund after write 37", hund_o, 8'h00);
  endtask

  task automatic t_time_carry;
    load(3'd3, 8'h12); load(3'd2, 8'h59); load(3'd1, 8'h58);
    ticks(99);
    chk("R1", "hund at 99", hund_o, 8'h99);
    ticks(1);
    chk("R1", "hund wrap", hund_o, 8'h00);
    chk("R3", "sec 58->59", sec_o, 8'h59);
    ticks(100);
    chk("R3", "sec wrap", sec_o, 8'h00);
    chk("R3", "min wrap", min_o, 8'h00);
    chk("R3", "hour 12->13", hour_o, 8'h13);
  endtask

  task automatic t_day;
    roll_day(8'h23, 8'h07, 8'h15, 8'h03, 8'h21);
    chk("R3", "hour wrap", hour_o, 8'h00);
    chk("R5", "wday 7->1", wday_o, 8'h01);
    chk("R5", "date 15->16", date_o, 8'h16);
    chk("R6", "month held", month_o, 8'h03);
    roll_day(8'h23, 8'h03, 8'h09, 8'h03, 8'h21);
    chk("R5", "wday 3->4", wday_o, 8'h04);
    chk("R5", "date 09->10", date_o, 8'h10);
  endtask

  task automatic t_months;
    roll_day(8'h23, 8'h01, 8'h30, 8'h04, 8'h21);
    chk("R6", "Apr 30 -> date", date_o, 8'h01);
    chk("R6", "Apr 30 -> month", month_o, 8'h05);
    roll_day(8'h23, 8'h01, 8'h30, 8'h01, 8'h21);
    chk("R6", "Jan 30 -> date", date_o, 8'h31);
    chk("R6", "Jan 30 -> month", month_o, 8'h01);
    roll_day(8'h23, 8'h01, 8'h31, 8'h01, 8'h21);
    chk("R6", "Jan 31 -> date", date_o, 8'h01);
    chk("R6", "Jan 31 -> month", month_o, 8'h02);
    roll_day(8'h23, 8'h01, 8'h30, 8'h11, 8'h21);
    chk("R6", "Nov 30 -> month", month_o, 8'h12);
  endtask

  task automatic t_feb;
    roll_day(8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    chk("R7", "Feb 28 y23 -> month", month_o, 8'h03);
    chk("R7", "Feb 28 y23 -> date", date_o, 8'h01);
    roll_day(8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    chk("R7", "Feb 28 y24 -> date", date_o, 8'h29);
    chk("R7", "Feb 28 y24 -> month", month_o, 8'h02);
    ticks(100); load(3'd3, 8'h23); load(3'd2, 8'h59); load(3'd1, 8'h59); ticks(100);
    chk("R7", "Feb 29 y24 -> month", month_o, 8'h03);
    roll_day(8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    chk("R7", "Feb 28 y00 -> date", date_o, 8'h29);
    roll_day(8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
    chk("R7", "Feb 28 y10 -> month", month_o, 8'h03);
    roll_day(8'h23, 8'h01, 8'h28, 8'h02, 8'h12);
    chk("R7", "Feb 28 y12 -> date", date_o, 8'h29);
  endtask

  task automatic t_year;
    roll_day(8'h23, 8'h01, 8'h31, 8'h12, 8'h45);
    chk("R8", "Dec 31 y45 -> year", year_o, 8'h46);
    chk("R8", "Dec 31 y45 -> month", month_o, 8'h01);
    roll_day(8'hA3, 8'h01, 8'h31, 8'h12, 8'h99);
    chk("R8", "y99 wrap -> year", year_o, 8'h00);
    chk("R4", "enable set, flag 0->1", hour_o, 8'hC0);
    roll_day(8'hE3, 8'h01, 8'h31, 8'h12, 8'h99);
    chk("R4", "enable set, flag 1->0", hour_o, 8'h80);
    roll_day(8'h63, 8'h01, 8'h31, 8'h12, 8'h99);
    chk("R4", "enable clear, flag held", hour_o, 8'h40);
    chk("R8", "y99 wrap date", date_o, 8'h01);
  endtask

  task automatic t_stop;
    load(3'd1, 8'h90);
    ticks(150);
    chk("R9", "stopped sec", sec_o, 8'h90);
    chk("R9", "stopped hund", hund_o, 8'h00);
    load(3'd1, 8'h10);
    ticks(99);
    chk("R9", "resumed hund", hund_o, 8'h99);
    chk("R9", "sec before 100th tick", sec_o, 8'h10);
    ticks(1);
    chk("R9", "sec after 100th tick", sec_o, 8'h11);
  endtask

  task automatic t_div_reset;
    ticks(37);
    chk("R10", "hund before load", hund_o, 8'h37);
    load(3'd2, 8'h22);
    chk("R10", "hund after minute load", hund_o, 8'h00);
    chk("R13", "minute loaded", min_o, 8'h22);
  endtask

  task automatic t_collide;
    ticks(3);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 3'd2; ld_data = 8'h05; tick = 1'b1;
    @(negedge clk);
    ld_en = 1'b0; tick = 1'b0;
    chk("R11", "hund on collision", hund_o, 8'h00);
    chk("R11", "min on collision", min_o, 8'h05);
    ticks(1);
    chk("R11", "hund after next tick", hund_o, 8'h01);
  endtask

  task automatic t_mask;
    load(3'd4, 8'hFD);
    chk("R13", "wday masked", wday_o, 8'h05);
    load(3'd6, 8'hE9);
    chk("R13", "month masked", month_o, 8'h09);
    load(3'd2, 8'hC7);
    chk("R13", "min masked", min_o, 8'h47);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hund();
    t_time_carry();
    t_day();
    t_months();
    t_feb();
    t_year();
    t_stop();
    t_div_reset();
    t_collide();
    t_mask();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule